// File: doc/BRIEF.md
# Keyed-Clear Watchdog Timer

This block supervises program execution in a small 8-bit controller. A binary up counter advances once for every tick of a slow internal oscillator. The tick arrives as a one-cycle enable in the system clock domain. When the count passes its top value, the block emits a one-cycle reset request and starts counting again from zero. With the default 13-bit counter the period is 8192 ticks. That gives 512 ms from a 16 kHz tick and 256 ms from a 32 kHz tick.

Software keeps the watchdog quiet by writing one fixed key value (0x5A by default) to a write-only restart register. A write of any other value has no effect. A static mode input decides how the watchdog runs. It can be switched off entirely. It can run only while the system is in its normal or slow power mode and stall in power-down or green mode. Or it can keep counting in every power mode.

Top module: `wdg_keyed`

## Requirements
- R1: In a running mode, starting from a zero count, the 2^CNT_W-th counted tick makes `wdt_rst` high for exactly one cycle. The pulse is visible in the cycle after the clock edge that samples that tick. No earlier tick pulses.
- R2: After a pulse the count is zero, so the next pulse needs another full 2^CNT_W counted ticks.
- R3: `mode_sel` = 0 or 3 means disabled. The count is held at zero and `wdt_rst` never rises.
- R4: `mode_sel` = 1 means gated. Ticks count only while `pwr_down` and `pwr_green` are both low. While either is high the count holds its value and resumes from it afterwards.
- R5: `mode_sel` = 2 means always running. Ticks count whatever the levels of `pwr_down` and `pwr_green`.
- R6: A cycle with `wr_en` high and `wr_data` equal to KEY (0x5A) returns the count to zero.
- R7: A write with any other `wr_data` value leaves the count, and therefore the time to the next pulse, unchanged.
- R8: When a key write and a tick fall in the same cycle, the restart wins. The count is zero afterwards and that tick is lost.
- R9: Cycles with `tick_en` low never advance the count.
- R10: While `rst_n` is low, and right after it is released, the count is zero and `wdt_rst` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Static mode: 0/3 off, 1 gated, 2 always running |
| tick_en | input | 1 | One-cycle strobe per slow-oscillator tick |
| pwr_down | input | 1 | System is in power-down mode |
| pwr_green | input | 1 | System is in green (light sleep) mode |
| wr_en | input | 1 | Write strobe for the restart register |
| wr_data | input | 8 | Data written to the restart register |
| wdt_rst | output | 1 | One-cycle reset request on overflow |

## Verification
Every result of this block is registered once. A tick, key write or reset sampled at one rising edge shows up on `wdt_rst` in the cycle right after that edge. The bench sets the inputs just after a falling edge and waits for the rising edge. It then advances its arithmetic count model and compares `wdt_rst` at the following falling edge. That edge is half a period after the only register update that could change the output. An ignored write or a stalled tick is judged by whether the next pulse arrives exactly when the model says it should.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [1:0] {
        WDG_OFF     = 2'd0,
        WDG_GATED   = 2'd1,
        WDG_ALWAYS  = 2'd2,
        WDG_OFF_ALT = 2'd3
    } wdg_mode_e;

endpackage

// File: rtl/wdg_run_gate.sv
module wdg_run_gate
    import wdg_pkg::*;
(
    input  wdg_mode_e mode,
    input  logic      tick_en,
    input  logic      pwr_down,
    input  logic      pwr_green,
    output logic      adv,
    output logic      off
);

    logic low_power;

    always_comb begin
        low_power = pwr_down | pwr_green;
        adv       = 1'b0;
        off       = 1'b0;
        case (mode)
            WDG_GATED:  adv = tick_en & ~low_power;
            WDG_ALWAYS: adv = tick_en;
            default:    off = 1'b1;
        endcase
    end

endmodule

// File: rtl/wdg_key_match.sv
module wdg_key_match #(
    parameter int                DATA_W = 8,
    parameter logic [DATA_W-1:0] KEY    = 8'h5A
) (
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              hit
);

    always_comb begin
        hit = wr_en && (wr_data == KEY);
    end

endmodule

// File: rtl/wdg_tick_counter.sv
module wdg_tick_counter #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             clr,
    input  logic             off,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_q
);

    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        if (clr || off) begin
            st_d.cnt = '0;
        end else if (adv) begin
            if (st_q.cnt == CNT_TOP) begin
                st_d.cnt = '0;
                st_d.ovf = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q = st_q.cnt;
    assign ovf_q = st_q.ovf;

    p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> !ovf_q);

    p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> (cnt_q == '0));

    p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0) && !ovf_q);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr && !off) |=> $stable(cnt_q) && !ovf_q);

endmodule

// File: rtl/wdg_keyed.sv
module wdg_keyed
    import wdg_pkg::*;
#(
    parameter int                CNT_W  = 13,
    parameter int                DATA_W = 8,
    parameter logic [DATA_W-1:0] KEY    = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              tick_en,
    input  logic              pwr_down,
    input  logic              pwr_green,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wdt_rst
);

    wdg_mode_e        mode;
    logic             adv;
    logic             off;
    logic             key_hit;
    logic [CNT_W-1:0] cnt;
    logic             ovf;

    assign mode = wdg_mode_e'(mode_sel);

    wdg_run_gate i_gate (
        .mode      (mode),
        .tick_en   (tick_en),
        .pwr_down  (pwr_down),
        .pwr_green (pwr_green),
        .adv       (adv),
        .off       (off)
    );

    wdg_key_match #(.DATA_W(DATA_W), .KEY(KEY)) i_key (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .hit     (key_hit)
    );

    wdg_tick_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .clr   (key_hit),
        .off   (off),
        .cnt_q (cnt),
        .ovf_q (ovf)
    );

    assign wdt_rst = ovf;

    p_off_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd0 || mode_sel == 2'd3) |=> !wdt_rst && (cnt == '0));

    p_gated_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd1 && (pwr_down || pwr_green) && !key_hit) |=> $stable(cnt));

    p_always_runs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd2 && tick_en && !key_hit && cnt != '1) |=> (cnt == $past(cnt) + 1'b1));

    p_tick_loses_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && wr_en && wr_data == KEY) |=> (cnt == '0) && !wdt_rst);

endmodule

// File: tb/test_wdg_keyed.sv
module test_wdg_keyed;

    localparam int       PERIOD = 10;
    localparam int       CW     = 4;
    localparam int       TOP    = (1 << CW) - 1;
    localparam bit [7:0] KEYV   = 8'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'd2;
    logic       tick_en = 1'b0;
    logic       pwr_down = 1'b0;
    logic       pwr_green = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wdt_rst;

    int n_checks = 0;
    int n_errors = 0;
    int m_cnt    = 0;
    bit m_pulse  = 1'b0;

    always #(PERIOD / 2) clk = ~clk;

    wdg_keyed #(.CNT_W(CW), .DATA_W(8), .KEY(KEYV)) i_wdg_keyed (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .tick_en   (tick_en),
        .pwr_down  (pwr_down),
        .pwr_green (pwr_green),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .wdt_rst   (wdt_rst)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: wdt_rst=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    // one cycle: drive after falling edge, model at rising edge, check at next falling edge
    task automatic cyc(input bit t, input bit w, input logic [7:0] d, input string tag);
        bit run;
        tick_en = t;
        wr_en   = w;
        wr_data = d;
        @(posedge clk);
        m_pulse = 1'b0;
        if (mode_sel == 2'd1)      run = t && !(pwr_down || pwr_green);
        else if (mode_sel == 2'd2) run = t;
        else                       run = 1'b0;
        if ((w && d == KEYV) || mode_sel == 2'd0 || mode_sel == 2'd3) begin
            m_cnt = 0;
        end else if (run) begin
            if (m_cnt == TOP) begin
                m_cnt = 0;
                m_pulse = 1'b1;
            end else begin
                m_cnt++;
            end
        end
        @(negedge clk);
        check(wdt_rst, m_pulse, tag);
        tick_en = 1'b0;
        wr_en   = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) begin
            @(negedge clk);
            check(wdt_rst, 1'b0, "R10");
        end
        rst_n = 1'b1;
        m_cnt = 0;
        m_pulse = 1'b0;
        cyc(1'b0, 1'b0, 8'h00, "R10");
    endtask

    initial begin
        #(PERIOD * 150000);
        n_errors++;
        $display("FAIL watchdog: run did not finish");
        summary();
    end

    initial begin
        do_reset();

        // R1, R2: pulse on the 16th tick, then again 16 ticks later
        mode_sel = 2'd2;
        do_reset();
        for (int i = 0; i < TOP; i++) cyc(1'b1, 1'b0, 8'h00, "R1");
        cyc(1'b1, 1'b0, 8'h00, "R1");
        check(wdt_rst, 1'b1, "R1");
        for (int i = 0; i < TOP; i++) cyc(1'b1, 1'b0, 8'h00, "R2");
        cyc(1'b1, 1'b0, 8'h00, "R2");
        check(wdt_rst, 1'b1, "R2");

        // R3, R4, R5: sweep every mode against every power combination
        for (int md = 0; md < 4; md++) begin
            for (int pw = 0; pw < 4; pw++) begin
                mode_sel  = 2'(md);
                pwr_down  = pw[1];
                pwr_green = pw[0];
                do_reset();
                for (int i = 0; i < 40; i++)
                    cyc(1'b1, 1'b0, 8'h00, md == 1 ? "R4" : (md == 2 ? "R5" : "R3"));
            end
        end
        pwr_down  = 1'b0;
        pwr_green = 1'b0;

        // R4: count held across a low-power stretch, resumes after
        mode_sel = 2'd1;
        do_reset();
        for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0, 8'h00, "R4");
        pwr_green = 1'b1;
        for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, 8'h00, "R4");
        pwr_green = 1'b0;
        pwr_down  = 1'b1;
        for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, 8'h00, "R4");
        pwr_down  = 1'b0;
        for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0, 8'h00, "R4");

        // R9: irregular tick pattern
        mode_sel = 2'd2;
        do_reset();
        for (int i = 0; i < 100; i++) cyc(bit'((i % 3) != 0), 1'b0, 8'h00, "R9");

        // R6, R7: every written value, 10 ticks in, then run to the pulse
        for (int v = 0; v < 256; v++) begin
            do_reset();
            for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0, 8'h00, "R7");
            cyc(1'b0, 1'b1, 8'(v), v == 8'h5A ? "R6" : "R7");
            for (int i = 0; i < 18; i++) cyc(1'b1, 1'b0, 8'h00, v == 8'h5A ? "R6" : "R7");
        end

        // R8: key write together with a tick, at several counts
        for (int k = 0; k <= TOP; k++) begin
            do_reset();
            for (int i = 0; i < k; i++) cyc(1'b1, 1'b0, 8'h00, "R8");
            cyc(1'b1, 1'b1, KEYV, "R8");
            for (int i = 0; i < TOP + 2; i++) cyc(1'b1, 1'b0, 8'h00, "R8");
        end

        // R10: reset in the middle of a count
        do_reset();
        for (int i = 0; i < 12; i++) cyc(1'b1, 1'b0, 8'h00, "R10");
        do_reset();
        for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, 8'h00, "R10");

        summary();
    end

endmodule